// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block decides whether one unsigned operand is below, equal to or above another, with one output line for each of the three results. It is built from identical 4-bit comparator slices. Each slice scans its bit pairs from the top down, and the first pair that differs settles the slice's result. When all four of a slice's pairs match, the slice does not decide anything itself: it forwards the verdict that arrives on its cascade inputs from the next less significant slice.

The top level chains a parameterised number of slices. The default is three, which gives 12-bit operands. The outputs of each slice drive the cascade inputs of its more significant neighbour. The least significant slice receives a fixed "equal so far" cascade word inside the block, so the caller sees only the two operands and the three result lines. The operands are plain unsigned magnitudes, so packed 8421-BCD digits compare correctly with the same logic. The block has no clock and holds no state.

Top module: `mag_cmp_chain`

## Requirements
- R1: In a slice, if the most significant differing bit pair (bit 3 scanned first, down to bit 0) has A=1 and B=0, the slice outputs {less,equal,greater} = 0,0,1 for any of the eight cascade input values.
- R2: In a slice, if that first differing pair has A=0 and B=1, the slice outputs 1,0,0 for any cascade input value.
- R3: In a slice with equal words, less-out equals less-in, equal-out equals equal-in, and the greater cascade input has no effect on any output.
- R4: In a slice with equal words, greater-out is 1 exactly when less-in and equal-in are both 0. With less-in and equal-in both 1, the outputs are 1,1,0.
- R5: At the top, lt_o, eq_o and gt_o equal the unsigned relations a_i<b_i, a_i==b_i and a_i>b_i over the full 4*NSLICES bits, and exactly one of them is high.
- R6: The least significant slice is tied to less=0, equal=1, greater=0, so equal operands (including all zeros and all ones) give eq_o=1 and lt_o=gt_o=0.
- R7: A difference in a more significant slice decides the result, whatever the less significant slices hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*NSLICES | Operand A, unsigned, bit 0 least significant |
| b_i | input | 4*NSLICES | Operand B, unsigned, bit 0 least significant |
| lt_o | output | 1 | High when A is below B |
| eq_o | output | 1 | High when A equals B |
| gt_o | output | 1 | High when A is above B |

## Verification
A single slice is swept over all 256 operand pairs, each with all eight cascade words. This separates the pairs that the local bits decide (R1, R2) from the equal pairs, where forwarding, the ignored greater input and the case with both less-in and equal-in high (R3, R4) are the only things that can go wrong. The chained top is then driven with all-zero and all-one operands, which exercise the internal tie-off. It also gets pairs that differ only in the lowest bit, which force the verdict to ripple through every slice, and pairs that differ in the top bit while the lower bits lean the other way, which show that the upper slice takes priority. Random operands, some with their upper slices forced equal, are compared against the unsigned relational operators.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  localparam int unsigned SLICE_W = 4;

  // Cascade / result word carried between slices
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } casc_t;

  // Cascade word presented to the least significant slice
  localparam casc_t CASC_SEED = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};

endpackage

// File: rtl/cmp_bit_rel.sv
// Relation of a single bit pair, kept as plain boolean terms so that
// unknown inputs stay unknown at the outputs.
module cmp_bit_rel (
  input  logic a_i,
  input  logic b_i,
  output logic above_o,
  output logic below_o,
  output logic same_o
);

  assign above_o = a_i & ~b_i;
  assign below_o = ~a_i & b_i;
  assign same_o  = ~(a_i ^ b_i);

endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
  import cmp_pkg::*;
#(
  parameter int unsigned SLICE_W = cmp_pkg::SLICE_W
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  casc_t              casc_i,
  output casc_t              casc_o
);

  localparam int unsigned NPAIRS = SLICE_W;

  logic [NPAIRS-1:0] above;
  logic [NPAIRS-1:0] below;
  logic [NPAIRS-1:0] same;

  // Running verdict, index k covers bits k-1..0; index 0 is "no bits yet"
  logic [NPAIRS:0] run_above;
  logic [NPAIRS:0] run_below;
  logic [NPAIRS:0] run_same;

  assign run_above[0] = 1'b0;
  assign run_below[0] = 1'b0;
  assign run_same[0]  = 1'b1;

  genvar gi;
  generate
    for (gi = 0; gi < NPAIRS; gi++) begin : g_pair
      cmp_bit_rel u_rel (
        .a_i     (a_i[gi]),
        .b_i     (b_i[gi]),
        .above_o (above[gi]),
        .below_o (below[gi]),
        .same_o  (same[gi])
      );
      // A higher pair that differs overrides whatever the lower pairs said
      assign run_above[gi+1] = above[gi] | (same[gi] & run_above[gi]);
      assign run_below[gi+1] = below[gi] | (same[gi] & run_below[gi]);
      assign run_same[gi+1]  = same[gi] & run_same[gi];
    end
  endgenerate

  logic loc_above;
  logic loc_below;
  logic loc_same;

  assign loc_above = run_above[NPAIRS];
  assign loc_below = run_below[NPAIRS];
  assign loc_same  = run_same[NPAIRS];

  // The greater cascade input plays no part in the result
  logic unused_casc_gt;
  assign unused_casc_gt = casc_i.gt;

  assign casc_o.lt = loc_below | (loc_same & casc_i.lt);
  assign casc_o.eq = loc_same & casc_i.eq;
  assign casc_o.gt = loc_above | (loc_same & ~casc_i.lt & ~casc_i.eq);

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import cmp_pkg::*;
#(
  parameter int unsigned NSLICES = 3
) (
  input  logic [4*NSLICES-1:0] a_i,
  input  logic [4*NSLICES-1:0] b_i,
  output logic                 lt_o,
  output logic                 eq_o,
  output logic                 gt_o
);

  localparam int unsigned SW    = cmp_pkg::SLICE_W;
  localparam int unsigned WIDTH = SW * NSLICES;

  // link[k] feeds slice k; link[NSLICES] is the final verdict
  casc_t link [NSLICES+1];

  assign link[0] = CASC_SEED;

  genvar gs;
  generate
    for (gs = 0; gs < NSLICES; gs++) begin : g_slice
      cmp_slice #(
        .SLICE_W (SW)
      ) u_slice (
        .a_i    (a_i[gs*SW +: SW]),
        .b_i    (b_i[gs*SW +: SW]),
        .casc_i (link[gs]),
        .casc_o (link[gs+1])
      );
    end
  endgenerate

  assign lt_o = link[NSLICES].lt;
  assign eq_o = link[NSLICES].eq;
  assign gt_o = link[NSLICES].gt;

endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
  parameter int unsigned NSLICES = 3
) (
  input logic [4*NSLICES-1:0] a_i,
  input logic [4*NSLICES-1:0] b_i,
  input logic                 lt_o,
  input logic                 eq_o,
  input logic                 gt_o
);

  localparam int unsigned WIDTH = 4 * NSLICES;
  localparam int unsigned TOPLO = WIDTH - 4;

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      AST_ONE_RESULT: assert ($countones({lt_o, eq_o, gt_o}) == 1); // R5
      AST_LT_MATCH: assert (lt_o == (a_i < b_i)); // R5
      AST_GT_MATCH: assert (gt_o == (a_i > b_i)); // R5
      AST_EQ_SEED: assert (!(a_i == b_i) || (eq_o && !lt_o && !gt_o)); // R6
      AST_TOP_DECIDES: assert (!(a_i[WIDTH-1:TOPLO] > b_i[WIDTH-1:TOPLO]) || gt_o); // R7
    end
  end

endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.NSLICES(NSLICES)) u_chk (
  .a_i  (a_i),
  .b_i  (b_i),
  .lt_o (lt_o),
  .eq_o (eq_o),
  .gt_o (gt_o)
);

// File: tb/mag_cmp_chain_test.sv
module mag_cmp_chain_test;
  import cmp_pkg::*;

  localparam int NS = 3;
  localparam int W  = 4 * NS;

  logic clk;
  logic rst_n;
  int   n_total;
  int   n_fail;
  bit   done;

  logic [W-1:0] a;
  logic [W-1:0] b;
  logic         lt, eq, gt;

  logic [3:0]   sa, sb;
  casc_t        scin, scout;

  mag_cmp_chain #(.NSLICES(NS)) uut (
    .a_i (a), .b_i (b), .lt_o (lt), .eq_o (eq), .gt_o (gt)
  );

  cmp_slice #(.SLICE_W(4)) uslice (
    .a_i (sa), .b_i (sb), .casc_i (scin), .casc_o (scout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act{lt,eq,gt}=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_top(input logic [W-1:0] x, input logic [W-1:0] y);
    return {x < y, x == y, x > y};
  endfunction

  task automatic top_case(input string tag, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    a = x;
    b = y;
    #1;
    chk(tag, {lt, eq, gt}, ref_top(x, y));
  endtask

  initial begin
    n_total = 0;
    n_fail  = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    a = '0; b = '0; sa = '0; sb = '0; scin = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R6 idle zeros", {lt, eq, gt}, 3'b010);
    rst_n = 1'b1;

    // Exhaustive single-slice sweep
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        for (int ic = 0; ic < 8; ic++) begin
          logic [2:0] exp;
          string      tag;
          @(negedge clk);
          sa   = 4'(ia);
          sb   = 4'(ib);
          scin = casc_t'(3'(ic));
          #1;
          if (ia > ib) begin
            exp = 3'b001; tag = "R1";
          end else if (ia < ib) begin
            exp = 3'b100; tag = "R2";
          end else begin
            exp = {scin.lt, scin.eq, ~scin.lt & ~scin.eq};
            tag = (scin.lt & scin.eq) ? "R4" : "R3";
          end
          chk(tag, {scout.lt, scout.eq, scout.gt}, exp);
        end
      end
    end

    // Chained corners
    top_case("R6 all zeros", '0, '0);
    top_case("R6 all ones", '1, '1);
    top_case("R5 lsb above", W'(1), W'(0));
    top_case("R5 lsb below", W'(0), W'(1));
    top_case("R5 lsb ones", '1, '1 - W'(1));
    top_case("R7 msb above", W'(1) << (W-1), (W'(1) << (W-1)) - W'(1));
    top_case("R7 msb below", (W'(1) << (W-1)) - W'(1), W'(1) << (W-1));

    // Random operands, some with upper slices forced equal
    for (int k = 0; k < 3000; k++) begin
      logic [W-1:0] x, y;
      x = W'($urandom);
      y = W'($urandom);
      if (k % 3 == 1) y[W-1:4] = x[W-1:4];
      if (k % 3 == 2) y[W-1:8] = x[W-1:8];
      top_case("R5 random", x, y);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

endmodule